// File: doc/BRIEF.md
# SPI EEPROM Sequential Byte Reader

This block fetches a run of bytes from a small serial EEPROM that has one-byte addressing and a four-wire SPI-style link (select, clock, data out, data in). A host hands it a first address, a byte count and a divider value with a single-cycle `start` pulse. The block then reads each byte as a self-contained transaction. It lowers select and shifts out the read opcode followed by the 8-bit address. It clocks in one data byte and raises select again. The byte goes back to the host on a one-cycle `rd_valid` strobe. The address then steps by one, wrapping past the top of the array, and the next transaction starts. A second command reads the device status register instead of array data and returns one byte.

After reset the block runs an initialisation preamble before it accepts any request. During the preamble select stays high and the clock makes two full pulses. `busy` covers this preamble and every request in progress. `done` marks the end of each request. The serial clock half-period is a whole number of system clocks taken from `half_div`, so the link speed does not depend on the system clock.

Top module: `spi_rom_reader`

## Requirements
- R1: After reset, `busy` is 1 and `spi_cs_n` is 1. Before `busy` first falls, `spi_sck` makes exactly two rising edges while `spi_cs_n` stays high. After that, the clock never rises while select is high.
- R2: Select is active low. `spi_cs_n` changes level only while `spi_sck` is low.
- R3: A data read holds `spi_cs_n` low for exactly 24 clock rising edges. The first 8 carry the opcode 8'h03, most significant bit first. The next 8 carry the byte address, most significant bit first.
- R4: `spi_mosi` changes only while `spi_sck` is low, so the device sees stable data at each rising edge.
- R5: The block takes `spi_miso` while the clock is low, after the falling edge. The last 8 such samples of a transaction form the returned byte, first sample as bit 7.
- R6: Byte k of a request is read from address (start_addr + k) mod 256, each byte in its own transaction. Address 255 is followed by address 0.
- R7: Each returned byte appears on `rd_data` during a one-cycle `rd_valid` pulse. A request of N bytes yields exactly N pulses, in address order.
- R8: A request with `status_rd`=1 holds select low for 16 rising edges and sends opcode 8'h05 in the first 8. It returns the status byte with one `rd_valid` pulse, whatever `byte_count` is.
- R9: `spi_sck` stays high and low for max(`half_div`,1) system clocks each. The value is captured when a request is accepted.
- R10: A `start` pulse while `busy` is 1 is ignored. The running request keeps its own address and count, and no extra bytes are returned.
- R11: `done` is a one-cycle pulse. It rises with `busy` falling, one half-period after select rises following the final byte.
- R12: A data request with `byte_count`=0 sets `done` in the cycle after `start` is accepted. There is no select or clock activity.
- R13: While `busy` is 0, `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only while idle |
| status_rd | input | 1 | 1: read the status register; 0: read array bytes |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to read (data mode) |
| half_div | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| busy | output | 1 | Preamble or request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| rd_valid | output | 1 | One-cycle strobe qualifying `rd_data` |
| rd_data | output | DATA_W | Returned byte |
| spi_cs_n | output | 1 | Device select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data toward the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume `rst` is held for at least one clock. They also assume `start` is a pulse that the host may raise at any time, busy or not. They take no stand on `spi_miso`, since a bad device can only corrupt data and not the link's timing. The bench's device model changes `spi_miso` only on falling clock edges while selected, which keeps it inside the sampling window the block relies on. The bench also changes `start`, `half_div` and the address fields only on falling system clock edges, and it raises `start` while busy on purpose once to exercise the ignore rule.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;
  localparam int          OPC_W    = 8;
  localparam logic [7:0]  OPC_READ = 8'h03;
  localparam logic [7:0]  OPC_STAT = 8'h05;

  typedef enum logic [2:0] {
    C_INIT, C_PRE, C_IDLE, C_LAUNCH, C_XFER, C_GAP
  } ctl_state_t;

  typedef enum logic [1:0] {
    E_IDLE, E_LOW, E_HIGH
  } eng_state_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb lim = (half_div == '0) ? DIV_W'(1) : half_div;

  assign tick = en && !restart && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en || restart) cnt <= '0;
    else if (tick)             cnt <= '0;
    else                       cnt <= cnt + DIV_W'(1);
  end

  // R9: the phase counter never passes the limit of the captured divider
  a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < lim));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int FRAME_W = 24,
  parameter int DATA_W  = 8,
  parameter int BC_W    = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  input  logic [BC_W-1:0]    nbits,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               done,
  output logic [DATA_W-1:0]  rx
);
  import spi_rom_pkg::*;

  eng_state_t         st;
  logic [FRAME_W-1:0] sh;
  logic [BC_W-1:0]    left;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= E_IDLE;
      sck  <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
      sh   <= '0;
      left <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          sh   <= frame << 1;
          mosi <= frame[FRAME_W-1];
          left <= nbits;
          sck  <= 1'b0;
          st   <= E_LOW;
        end
        E_LOW: if (tick) begin
          rx  <= {rx[DATA_W-2:0], miso};
          sck <= 1'b1;
          st  <= E_HIGH;
        end
        E_HIGH: if (tick) begin
          sck <= 1'b0;
          if (left == BC_W'(1)) begin
            done <= 1'b1;
            st   <= E_IDLE;
          end else begin
            mosi <= sh[FRAME_W-1];
            sh   <= sh << 1;
            left <= left - BC_W'(1);
            st   <= E_LOW;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R4: outgoing data holds while the clock is high
  a_r4_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));
  // R2: the clock is low whenever the engine is not shifting
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    (st == E_IDLE) |-> !sck);
endmodule

// File: rtl/spi_rom_reader.sv
module spi_rom_reader #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 9,
  parameter int DIV_W    = 8,
  parameter int INIT_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              status_rd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [DIV_W-1:0]  half_div,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  import spi_rom_pkg::*;

  localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
  localparam int BC_W    = $clog2(FRAME_W + 1);
  localparam logic [BC_W-1:0] NB_READ = BC_W'(FRAME_W);
  localparam logic [BC_W-1:0] NB_STAT = BC_W'(OPC_W + DATA_W);
  localparam logic [BC_W-1:0] NB_PRE  = BC_W'(2);

  ctl_state_t         st;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   remain;
  logic               mode_stat;
  logic [DIV_W-1:0]   div_q;

  logic               eng_go, eng_done, tick, tick_en, tick_restart;
  logic [FRAME_W-1:0] eng_frame;
  logic [BC_W-1:0]    eng_nbits;
  logic [DATA_W-1:0]  eng_rx;

  always_comb begin
    eng_go    = (st == C_INIT) || (st == C_LAUNCH);
    eng_frame = '0;
    eng_nbits = NB_PRE;
    if (st != C_INIT) begin
      if (mode_stat) begin
        eng_frame = {OPC_STAT, {(FRAME_W-OPC_W){1'b0}}};
        eng_nbits = NB_STAT;
      end else begin
        eng_frame = {OPC_READ, addr_q, {DATA_W{1'b0}}};
        eng_nbits = NB_READ;
      end
    end
    tick_en      = (st != C_IDLE);
    tick_restart = eng_go || ((st == C_XFER) && eng_done);
  end

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .restart(tick_restart),
    .half_div(div_q), .tick(tick)
  );

  spi_frame_engine #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .BC_W(BC_W)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .go(eng_go), .frame(eng_frame),
    .nbits(eng_nbits), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .done(eng_done), .rx(eng_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_INIT;
      spi_cs_n  <= 1'b1;
      busy      <= 1'b1;
      done      <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      addr_q    <= '0;
      remain    <= '0;
      mode_stat <= 1'b0;
      div_q     <= DIV_W'(INIT_DIV);
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        C_INIT: st <= C_PRE;
        C_PRE: if (eng_done) begin
          st   <= C_IDLE;
          busy <= 1'b0;
        end
        C_IDLE: if (start) begin
          div_q     <= half_div;
          addr_q    <= start_addr;
          mode_stat <= status_rd;
          if (status_rd) begin
            remain <= CNT_W'(1);
            busy   <= 1'b1;
            st     <= C_LAUNCH;
          end else if (byte_count == '0) begin
            done <= 1'b1;
          end else begin
            remain <= byte_count;
            busy   <= 1'b1;
            st     <= C_LAUNCH;
          end
        end
        C_LAUNCH: begin
          spi_cs_n <= 1'b0;
          st       <= C_XFER;
        end
        C_XFER: if (eng_done) begin
          spi_cs_n <= 1'b1;
          rd_valid <= 1'b1;
          rd_data  <= eng_rx;
          remain   <= remain - CNT_W'(1);
          if (!mode_stat) addr_q <= addr_q + ADDR_W'(1);
          st       <= C_GAP;
        end
        C_GAP: if (tick) begin
          if (remain == '0) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= C_IDLE;
          end else begin
            st <= C_LAUNCH;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R13: deselected whenever idle
  a_r13_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);
  // R2: select only moves while the clock is low
  a_r2_cs_edge_clk_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_cs_n) |-> !spi_sck);
  // R11: done lasts one cycle and coincides with idle
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: the byte strobe lasts one cycle
  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R10: a request in flight keeps its captured divider
  a_r10_div_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: tb/tb_spi_rom_reader.sv
module tb_spi_rom_reader;
  localparam logic [7:0] STATUS_VAL = 8'h3C;
  localparam int         WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, status_rd = 1'b0;
  logic [7:0] start_addr = '0;
  logic [8:0] byte_count = '0;
  logic [7:0] half_div = 8'd1;
  logic       busy, done, rd_valid, spi_cs_n, spi_sck, spi_mosi;
  logic [7:0] rd_data;
  logic       spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_rom_reader dut (
    .clk(clk), .rst(rst), .start(start), .status_rd(status_rd),
    .start_addr(start_addr), .byte_count(byte_count), .half_div(half_div),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_val(input logic [7:0] a);
    return a * 8'd29 + 8'd7;
  endfunction

  // device model
  int         m_cnt = 0;
  logic [7:0] m_op = '0, m_addr = '0;
  int         desel_rises = 0, cs_falls = 0;

  always @(posedge spi_sck) begin
    if (spi_cs_n) desel_rises++;
    else begin
      if (m_cnt < 8)       m_op   = {m_op[6:0], spi_mosi};
      else if (m_cnt < 16) m_addr = {m_addr[6:0], spi_mosi};
      m_cnt++;
    end
  end
  always @(negedge spi_sck) begin
    if (!spi_cs_n) begin
      if (m_op == 8'h05 && m_cnt >= 8 && m_cnt < 16)
        spi_miso = STATUS_VAL[15 - m_cnt];
      else if (m_op == 8'h03 && m_cnt >= 16 && m_cnt < 24)
        spi_miso = rom_val(m_addr)[23 - m_cnt];
    end
  end
  always @(negedge spi_cs_n) cs_falls++;
  always @(posedge spi_cs_n) begin
    if (m_cnt != 0) begin
      if (m_op == 8'h03)      chk(m_cnt == 24, "R3 read frame clocks", m_cnt, 24);
      else if (m_op == 8'h05) chk(m_cnt == 16, "R8 status frame clocks", m_cnt, 16);
      else                    chk(1'b0, "R3 opcode", m_op, 3);
    end
    m_cnt = 0;
  end

  // scoreboard monitor and edge-rule watchers
  logic [7:0] exp_q[$];
  int   unexpected = 0, v_r2 = 0, v_r4 = 0, v_r7 = 0;
  int   hi_run = 0, last_hi = 0;
  logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0, p_valid = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          unexpected++;
          chk(1'b0, "R10 unexpected byte", rd_data, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R5 R6 returned byte", rd_data, e);
        end
      end
      if (spi_cs_n != p_cs && spi_sck) v_r2++;
      if (spi_sck && p_sck && spi_mosi != p_mosi) v_r4++;
      if (rd_valid && p_valid) v_r7++;
      if (spi_sck) hi_run++;
      else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
    end
    p_cs = spi_cs_n; p_sck = spi_sck; p_mosi = spi_mosi; p_valid = rd_valid;
  end

  task automatic do_read(input logic [7:0] a, input int n, input bit st, input logic [7:0] dv);
    @(negedge clk);
    start_addr = a; byte_count = 9'(n); status_rd = st; half_div = dv; start = 1'b1;
    if (st) exp_q.push_back(STATUS_VAL);
    else for (int i = 0; i < n; i++) exp_q.push_back(rom_val(a + 8'(i)));
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(exp_q.size() == 0, "R7 every byte returned before done", exp_q.size(), 0);
    chk(!busy, "R11 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done && !busy, "R11 done single cycle", done, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(busy && spi_cs_n && !spi_sck, "R1 reset state", {busy, spi_cs_n, spi_sck}, 6);
    while (busy) @(negedge clk);
    chk(desel_rises == 2, "R1 init preamble pulses", desel_rises, 2);
    chk(cs_falls == 0, "R1 select high through preamble", cs_falls, 0);

    do_read(8'd10, 3, 1'b0, 8'd1);
    chk(last_hi == 1, "R9 half period div=1", last_hi, 1);
    do_read(8'd254, 4, 1'b0, 8'd3);
    chk(last_hi == 3, "R9 half period div=3", last_hi, 3);
    do_read(8'd77, 1, 1'b0, 8'd0);
    chk(last_hi == 1, "R9 half period div=0", last_hi, 1);
    do_read(8'd0, 5, 1'b1, 8'd2);
    chk(last_hi == 2, "R8 R9 status half period", last_hi, 2);

    begin
      int f0;
      f0 = cs_falls;
      @(negedge clk);
      byte_count = '0; status_rd = 1'b0; start_addr = 8'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !busy, "R12 zero count done next cycle", done, 1);
      @(negedge clk);
      chk(!done, "R12 R11 done single cycle", done, 0);
      repeat (20) @(negedge clk);
      chk(cs_falls == f0 && spi_cs_n, "R12 R13 no bus activity", cs_falls - f0, 0);
    end

    begin
      @(negedge clk);
      start_addr = 8'd20; byte_count = 9'd2; status_rd = 1'b0; half_div = 8'd2; start = 1'b1;
      exp_q.push_back(rom_val(8'd20));
      exp_q.push_back(rom_val(8'd21));
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      chk(busy, "R10 still busy before second start", busy, 1);
      start_addr = 8'd100; byte_count = 9'd5; half_div = 8'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk(last_hi == 2, "R10 divider kept", last_hi, 2);
      repeat (300) @(negedge clk);
      chk(unexpected == 0 && exp_q.size() == 0, "R10 start ignored while busy",
          unexpected, 0);
    end

    chk(desel_rises == 2, "R1 no clock while deselected", desel_rises, 2);
    chk(v_r2 == 0, "R2 select edge with clock low", v_r2, 0);
    chk(v_r4 == 0, "R4 data stable while clock high", v_r4, 0);
    chk(v_r7 == 0, "R7 strobe one cycle", v_r7, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule